// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds a processor's general registers and status words, 32 bits each and 37 in all. Where a logical index lands in storage depends on the operating mode held in the low five bits of the current status word. Indices 0 to 7 and the program counter (index 15) always reach the same storage. The fast-interrupt mode has its own indices 8 to 14. The other four exception modes each have their own stack pointer (13) and link register (14). User mode, System mode and any unlisted mode code all use the base set.

Two combinational read ports and one write port share a 4-bit index and always use the current mode. A second set of ports reads and writes the saved status word of the current mode. An exception-entry request does three things in one edge: it stores a return address in the target mode's link register, copies the current status into the target mode's saved status, and switches the mode field to the target. Reset starts the block in Supervisor mode.

Top module: `banked_regfile`

## Requirements
- R1: While reset is low and just after it is released, every register and saved status word reads zero, and the current status reads 0x00000013 (Supervisor).
- R2: Mode codes sit in status bits [4:0]: User 10000, fast-interrupt 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011, System 11111. Indices 0–7 and 15 reach the same storage in every mode.
- R3: In fast-interrupt mode (10001), indices 8–14 reach storage that no other mode can reach.
- R4: In IRQ, Supervisor, Abort and Undefined modes, indices 13 and 14 are private to each mode, and indices 8–12 are shared with User mode.
- R5: System mode, and any code not in the R2 list, use exactly the User register set.
- R6: Each of the five exception modes has its own saved status word, read on the saved-status read port and written by the saved-status write strobe while that mode is current.
- R7: In User, System or an unlisted mode, the saved-status read port returns zero and any write is dropped. The error output is high in any cycle where the read or write strobe is high in such a mode.
- R8: An exception-entry request to one of the five exception modes does all of the following on one edge: the target's r14 takes the link input, the target's saved status takes the current status, and status bits [4:0] take the target code while the upper bits are kept. Status and saved-status writes in that same cycle are dropped. If the general write targets the same storage, the link value wins.
- R9: An exception-entry request whose target code is not one of the five exception modes has no effect.
- R10: Reads are combinational. A general write in the same cycle to the same index is forwarded to the read port, and a saved-status write that is not dropped is forwarded to the saved-status read port. Exception-entry effects appear from the next cycle.
- R11: When no exception entry takes place, the status write strobe replaces the whole current status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_idx_i | input | 4 | Read port A index |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B index |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write index |
| wr_data_i | input | 32 | General write data |
| stat_we_i | input | 1 | Current status write strobe |
| stat_wdata_i | input | 32 | Current status write data |
| stat_o | output | 32 | Current status word |
| sav_re_i | input | 1 | Saved status read strobe (drives the error flag only) |
| sav_we_i | input | 1 | Saved status write strobe |
| sav_wdata_i | input | 32 | Saved status write data |
| sav_rdata_o | output | 32 | Saved status of the current mode |
| sav_err_o | output | 1 | Saved status access in a mode without one |
| exc_req_i | input | 1 | Exception-entry request |
| exc_mode_i | input | 5 | Exception target mode code |
| exc_link_i | input | 32 | Return address for the target r14 |

## Verification
The bench builds the block at its default 32-bit data width. At that width the 31 general storage slots, the five saved status words and the full 32-bit status word are all reachable. The bench drives every listed mode code and the unlisted code 00000, so every banking path is exercised. A long stretch of random traffic then mixes exception entries with writes that collide with them in the same cycle.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int MODE_W   = 5;
  localparam int IDX_W    = 4;
  localparam int N_RD     = 2;
  localparam int N_SLOT   = 31;              // 30 general + program counter
  localparam int SLOT_W   = $clog2(N_SLOT);
  localparam int PC_SLOT  = N_SLOT - 1;
  localparam int FAST_BASE = 15;             // fast-interrupt r8..r14
  localparam int PRIV_BASE = 22;             // sp/lr pairs, IRQ first
  localparam int N_SAV    = 5;

  localparam logic [IDX_W-1:0] IDX_BANK_LO = IDX_W'(8);
  localparam logic [IDX_W-1:0] IDX_SP      = IDX_W'(13);
  localparam logic [IDX_W-1:0] IDX_LR      = IDX_W'(14);
  localparam logic [IDX_W-1:0] IDX_PC      = IDX_W'(15);

  typedef enum logic [MODE_W-1:0] {
    MD_USR  = 5'b10000,
    MD_FAST = 5'b10001,
    MD_IRQ  = 5'b10010,
    MD_SUP  = 5'b10011,
    MD_ABT  = 5'b10111,
    MD_UND  = 5'b11011,
    MD_SYS  = 5'b11111
  } mode_e;

  // order of the last four fixes the sp/lr pair layout
  typedef enum logic [2:0] {
    BK_USR, BK_FAST, BK_IRQ, BK_SUP, BK_ABT, BK_UND
  } bank_e;

  function automatic bank_e bank_of(logic [MODE_W-1:0] m);
    case (m)
      MD_FAST: return BK_FAST;
      MD_IRQ:  return BK_IRQ;
      MD_SUP:  return BK_SUP;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  bank_e              bank_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [SLOT_W-1:0]  slot_o
);
  logic [SLOT_W-1:0] pair_base;

  assign pair_base = SLOT_W'(PRIV_BASE + 2 * (int'(bank_i) - int'(BK_IRQ)));

  always_comb begin
    slot_o = SLOT_W'(idx_i);
    if (idx_i == IDX_PC) begin
      slot_o = SLOT_W'(PC_SLOT);
    end else if (idx_i >= IDX_BANK_LO) begin
      if (bank_i == BK_FAST)
        slot_o = SLOT_W'(FAST_BASE) + SLOT_W'(idx_i - IDX_BANK_LO);
      else if (idx_i >= IDX_SP && bank_i != BK_USR)
        slot_o = pair_base + SLOT_W'(idx_i - IDX_SP);
    end
  end
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int DATA_W = 32,
  parameter int N      = 31,
  parameter int SW     = 5,
  parameter int NRD    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SW-1:0]              wslot_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       lk_we_i,
  input  logic [SW-1:0]              lk_slot_i,
  input  logic [DATA_W-1:0]          lk_data_i,
  input  logic [NRD-1:0][SW-1:0]     rslot_i,
  output logic [NRD-1:0][DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** SW;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    if (s < N) begin : g_live
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            q <= '0;
        else if (lk_we_i && lk_slot_i == SW'(s)) q <= lk_data_i;   // link wins
        else if (we_i && wslot_i == SW'(s))      q <= wdata_i;
      end
      assign mem[s] = q;
    end else begin : g_pad
      assign mem[s] = '0;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = (we_i && wslot_i == rslot_i[r]) ? wdata_i : mem[rslot_i[r]];
  end
endmodule

// File: rtl/status_unit.sv
module status_unit
  import bank_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] RST_STAT = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stat_we_i,
  input  logic [DATA_W-1:0]   stat_wdata_i,
  input  logic                sav_re_i,
  input  logic                sav_we_i,
  input  logic [DATA_W-1:0]   sav_wdata_i,
  input  logic                exc_fire_i,
  input  bank_e               exc_bank_i,
  input  logic [MODE_W-1:0]   exc_mode_i,
  output logic [DATA_W-1:0]   stat_o,
  output bank_e               cur_bank_o,
  output logic [DATA_W-1:0]   sav_rdata_o,
  output logic                sav_err_o
);
  localparam int SIW = $clog2(N_SAV);

  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] sav_q [2**SIW];
  bank_e             cur_bank;
  logic              has_sav;
  logic [SIW-1:0]    cur_sidx;
  logic              sav_wr_ok;

  assign cur_bank  = bank_of(stat_q[MODE_W-1:0]);
  assign has_sav   = (cur_bank != BK_USR);
  assign cur_sidx  = has_sav ? SIW'(int'(cur_bank) - 1) : '0;
  assign sav_wr_ok = sav_we_i && !exc_fire_i && has_sav;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_q <= RST_STAT;
    else if (exc_fire_i) stat_q <= {stat_q[DATA_W-1:MODE_W], exc_mode_i};
    else if (stat_we_i)  stat_q <= stat_wdata_i;
  end

  for (genvar k = 0; k < 2**SIW; k++) begin : g_sav
    if (k < N_SAV) begin : g_live
      localparam bank_e OWN = bank_e'(3'(k + 1));
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= '0;
        else if (exc_fire_i && exc_bank_i == OWN)   q <= stat_q;
        else if (sav_wr_ok && cur_bank == OWN)      q <= sav_wdata_i;
      end
      assign sav_q[k] = q;
    end else begin : g_pad
      assign sav_q[k] = '0;
    end
  end

  always_comb begin
    sav_rdata_o = '0;
    if (sav_wr_ok)    sav_rdata_o = sav_wdata_i;
    else if (has_sav) sav_rdata_o = sav_q[cur_sidx];
  end

  assign sav_err_o  = (sav_re_i || sav_we_i) && !has_sav;
  assign stat_o     = stat_q;
  assign cur_bank_o = cur_bank;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         ra_idx_i,
  output logic [DATA_W-1:0]  ra_data_o,
  input  logic [3:0]         rb_idx_i,
  output logic [DATA_W-1:0]  rb_data_o,
  input  logic               wr_en_i,
  input  logic [3:0]         wr_idx_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               stat_we_i,
  input  logic [DATA_W-1:0]  stat_wdata_i,
  output logic [DATA_W-1:0]  stat_o,
  input  logic               sav_re_i,
  input  logic               sav_we_i,
  input  logic [DATA_W-1:0]  sav_wdata_i,
  output logic [DATA_W-1:0]  sav_rdata_o,
  output logic               sav_err_o,
  input  logic               exc_req_i,
  input  logic [4:0]         exc_mode_i,
  input  logic [DATA_W-1:0]  exc_link_i
);
  localparam logic [DATA_W-1:0] RST_STAT = DATA_W'(MD_SUP);

  bank_e                         cur_bank;
  bank_e                         exc_bank;
  logic                          exc_fire;
  logic [IDX_W-1:0]              rd_idx [N_RD];
  logic [N_RD-1:0][SLOT_W-1:0]   rd_slot;
  logic [N_RD-1:0][DATA_W-1:0]   rd_data;
  logic [SLOT_W-1:0]             wr_slot;
  logic [SLOT_W-1:0]             lk_slot;

  assign exc_bank = bank_of(exc_mode_i);
  assign exc_fire = exc_req_i && (exc_bank != BK_USR);

  assign rd_idx[0] = ra_idx_i;
  assign rd_idx[1] = rb_idx_i;

  for (genvar p = 0; p < N_RD; p++) begin : g_rmap
    bank_map u_map (.bank_i(cur_bank), .idx_i(rd_idx[p]), .slot_o(rd_slot[p]));
  end

  bank_map u_wmap (.bank_i(cur_bank), .idx_i(wr_idx_i), .slot_o(wr_slot));
  bank_map u_lmap (.bank_i(exc_bank), .idx_i(IDX_LR),   .slot_o(lk_slot));

  gpr_array #(
    .DATA_W(DATA_W), .N(N_SLOT), .SW(SLOT_W), .NRD(N_RD)
  ) u_gpr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i),
    .wslot_i   (wr_slot),
    .wdata_i   (wr_data_i),
    .lk_we_i   (exc_fire),
    .lk_slot_i (lk_slot),
    .lk_data_i (exc_link_i),
    .rslot_i   (rd_slot),
    .rdata_o   (rd_data)
  );

  status_unit #(
    .DATA_W(DATA_W), .RST_STAT(RST_STAT)
  ) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stat_we_i    (stat_we_i),
    .stat_wdata_i (stat_wdata_i),
    .sav_re_i     (sav_re_i),
    .sav_we_i     (sav_we_i),
    .sav_wdata_i  (sav_wdata_i),
    .exc_fire_i   (exc_fire),
    .exc_bank_i   (exc_bank),
    .exc_mode_i   (exc_mode_i),
    .stat_o       (stat_o),
    .cur_bank_o   (cur_bank),
    .sav_rdata_o  (sav_rdata_o),
    .sav_err_o    (sav_err_o)
  );

  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         ra_idx_i,
  input logic [DATA_W-1:0]  ra_data_o,
  input logic [3:0]         rb_idx_i,
  input logic [DATA_W-1:0]  rb_data_o,
  input logic               wr_en_i,
  input logic [3:0]         wr_idx_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               stat_we_i,
  input logic [DATA_W-1:0]  stat_wdata_i,
  input logic [DATA_W-1:0]  stat_o,
  input logic               sav_re_i,
  input logic               sav_we_i,
  input logic [DATA_W-1:0]  sav_wdata_i,
  input logic [DATA_W-1:0]  sav_rdata_o,
  input logic               sav_err_o,
  input logic               exc_req_i,
  input logic [4:0]         exc_mode_i,
  input logic [DATA_W-1:0]  exc_link_i
);
  logic exc_ok;
  assign exc_ok = exc_req_i &&
                  (exc_mode_i inside {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011});

  // R7
  sav_err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_err_o |-> sav_rdata_o == '0);

  // R7
  sav_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_err_o |-> (sav_re_i || sav_we_i));

  // R8
  exc_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ok |=> stat_o[4:0] == $past(exc_mode_i));

  // R8
  exc_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ok |=> (sav_we_i || sav_rdata_o == $past(stat_o)));

  // R9
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_we_i && !exc_ok) |=> $stable(stat_o));

  // R10
  fwd_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == ra_idx_i) |-> ra_data_o == wr_data_i);
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [3:0]  ra_idx_i, rb_idx_i, wr_idx_i;
  logic [31:0] ra_data_o, rb_data_o, wr_data_i;
  logic        wr_en_i, stat_we_i, sav_re_i, sav_we_i, sav_err_o, exc_req_i;
  logic [31:0] stat_wdata_i, stat_o, sav_wdata_i, sav_rdata_o, exc_link_i;
  logic [4:0]  exc_mode_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk_i = ~clk_i;

  banked_regfile u_banked_regfile (.*);

  // reference state
  logic [31:0] m_usr [16];
  logic [31:0] m_fast[16];
  logic [31:0] m_sp  [6];
  logic [31:0] m_lr  [6];
  logic [31:0] m_sav [6];
  logic [31:0] m_stat;

  logic [4:0] mlist [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00};

  function automatic int kind(logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mread(int k, logic [3:0] i);
    if (i < 8 || i == 15) return m_usr[i];
    if (k == 1) return m_fast[i];
    if (k >= 2 && i == 13) return m_sp[k];
    if (k >= 2 && i == 14) return m_lr[k];
    return m_usr[i];
  endfunction

  task automatic mwrite(int k, logic [3:0] i, logic [31:0] v);
    if (i < 8 || i == 15) m_usr[i] = v;
    else if (k == 1) m_fast[i] = v;
    else if (k >= 2 && i == 13) m_sp[k] = v;
    else if (k >= 2 && i == 14) m_lr[k] = v;
    else m_usr[i] = v;
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 0; stat_we_i = 0; sav_re_i = 0; sav_we_i = 0; exc_req_i = 0;
  endtask

  // compare mid-cycle, then advance one edge and update the model
  task automatic step(string tag);
    int kc, ke;
    bit fire;
    logic [31:0] old;
    #1;
    kc   = kind(m_stat[4:0]);
    ke   = kind(exc_mode_i);
    fire = exc_req_i && ke != 0;
    check(tag, "ra", ra_data_o, (wr_en_i && wr_idx_i == ra_idx_i) ? wr_data_i : mread(kc, ra_idx_i));
    check(tag, "rb", rb_data_o, (wr_en_i && wr_idx_i == rb_idx_i) ? wr_data_i : mread(kc, rb_idx_i));
    check(tag, "stat", stat_o, m_stat);
    check(tag, "sav", sav_rdata_o,
          (kc == 0) ? 32'h0 : (sav_we_i && !fire) ? sav_wdata_i : m_sav[kc]);
    check(tag, "err", {31'h0, sav_err_o}, {31'h0, (sav_re_i || sav_we_i) && kc == 0});
    @(posedge clk_i);
    old = m_stat;
    if (wr_en_i) mwrite(kc, wr_idx_i, wr_data_i);
    if (fire) begin
      mwrite(ke, 4'd14, exc_link_i);
      m_sav[ke] = old;
      m_stat = {old[31:5], exc_mode_i};
    end else begin
      if (sav_we_i && kc != 0) m_sav[kc] = sav_wdata_i;
      if (stat_we_i) m_stat = stat_wdata_i;
    end
    @(negedge clk_i);
    idle();
  endtask

  task automatic set_mode(logic [4:0] m, string tag);
    stat_we_i = 1; stat_wdata_i = {27'h0, m};
    step(tag);
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] v, string tag);
    wr_en_i = 1; wr_idx_i = i; wr_data_i = v;
    step(tag);
  endtask

  task automatic rd(logic [3:0] a, logic [3:0] b, string tag);
    ra_idx_i = a; rb_idx_i = b;
    step(tag);
  endtask

  function automatic string mtag(logic [4:0] m);
    case (kind(m))
      0: return (m == 5'h10) ? "R2" : "R5";
      1: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 0;
    idle();
    ra_idx_i = 0; rb_idx_i = 0; wr_idx_i = 0; wr_data_i = 0;
    stat_wdata_i = 0; sav_wdata_i = 0; exc_mode_i = 0; exc_link_i = 0;
    for (int i = 0; i < 16; i++) begin m_usr[i] = 0; m_fast[i] = 0; end
    for (int k = 0; k < 6; k++) begin m_sp[k] = 0; m_lr[k] = 0; m_sav[k] = 0; end
    m_stat = 32'h13;
    repeat (3) @(negedge clk_i);
    // R1: state during reset
    #1;
    check("R1", "stat_in_reset", stat_o, 32'h13);
    check("R1", "ra_in_reset", ra_data_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1: everything zero after release, Supervisor mode
    for (int i = 0; i < 16; i++) rd(4'(i), 4'(15 - i), "R1");
    sav_re_i = 1; step("R1");

    // R2 R3 R4 R5: fill every index in every mode, then read back
    for (int mi = 0; mi < 8; mi++) begin
      set_mode(mlist[mi], mtag(mlist[mi]));
      for (int i = 0; i < 16; i++)
        wr(4'(i), {8'(mi), 8'(i), 16'hA5C3}, mtag(mlist[mi]));
    end
    for (int mi = 0; mi < 8; mi++) begin
      set_mode(mlist[mi], mtag(mlist[mi]));
      for (int i = 0; i < 16; i++) rd(4'(i), 4'(15 - i), mtag(mlist[mi]));
    end

    // R6 R7: saved status per mode
    for (int mi = 0; mi < 8; mi++) begin
      set_mode(mlist[mi], "R6");
      sav_we_i = 1; sav_re_i = 1; sav_wdata_i = {24'hC0FFEE, 3'b0, mlist[mi]};
      step(kind(mlist[mi]) == 0 ? "R7" : "R6");
      sav_re_i = 1;
      step(kind(mlist[mi]) == 0 ? "R7" : "R6");
    end
    for (int mi = 0; mi < 8; mi++) begin
      set_mode(mlist[mi], "R6");
      sav_re_i = 1; step(kind(mlist[mi]) == 0 ? "R7" : "R6");
    end

    // R11: whole status word replaced
    stat_we_i = 1; stat_wdata_i = 32'hF00D_0012; step("R11");
    step("R11");

    // R8: entry from IRQ-with-flags to Undefined, colliding status writes dropped
    exc_req_i = 1; exc_mode_i = 5'h1B; exc_link_i = 32'h1111_2222;
    stat_we_i = 1; stat_wdata_i = 32'h0000_0010;
    sav_we_i = 1; sav_wdata_i = 32'hDEAD_BEEF;
    step("R8");
    rd(14, 13, "R8");
    sav_re_i = 1; step("R8");
    // R8: same-mode entry with general write to the same r14, link wins
    exc_req_i = 1; exc_mode_i = 5'h1B; exc_link_i = 32'h3333_4444;
    wr_en_i = 1; wr_idx_i = 14; wr_data_i = 32'h5555_6666; ra_idx_i = 14;
    step("R8");
    rd(14, 0, "R8");
    // R8: entry into fast-interrupt mode, banked r14
    exc_req_i = 1; exc_mode_i = 5'h11; exc_link_i = 32'h7777_8888;
    step("R8");
    rd(14, 8, "R8");
    sav_re_i = 1; step("R8");

    // R9: entries to non-exception targets ignored
    foreach (mlist[j]) if (kind(mlist[j]) == 0) begin
      exc_req_i = 1; exc_mode_i = mlist[j]; exc_link_i = 32'hBAD0_0000 | 32'(j);
      step("R9");
      rd(14, 13, "R9");
    end

    // R10: forwarding on both ports and on saved status
    wr_en_i = 1; wr_idx_i = 3; wr_data_i = 32'h0F0F_1234; ra_idx_i = 3; rb_idx_i = 3;
    step("R10");
    sav_we_i = 1; sav_wdata_i = 32'h8765_4321; step("R10");

    // R10: random traffic against the reference model
    for (int n = 0; n < 6000; n++) begin
      ra_idx_i = 4'($urandom); rb_idx_i = 4'($urandom);
      wr_en_i = $urandom_range(0, 1); wr_idx_i = 4'($urandom); wr_data_i = $urandom;
      stat_we_i = ($urandom_range(0, 7) == 0);
      stat_wdata_i = {$urandom_range(0, 255), 19'h0, mlist[$urandom_range(0, 7)]};
      sav_re_i = $urandom_range(0, 1); sav_we_i = $urandom_range(0, 1); sav_wdata_i = $urandom;
      exc_req_i = ($urandom_range(0, 15) == 0);
      exc_mode_i = mlist[$urandom_range(0, 7)]; exc_link_i = $urandom;
      step("R10");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule